// File: doc/BRIEF.md
# Dual-Clock FIFO with Synchronized Status Flags

This block is a 64-entry, 36-bit first-in first-out buffer. Its write side and its read side run on separate clocks, and the two clocks may have no phase or frequency relation. A producer pushes words on the write clock. A consumer pops them on the read clock into a registered output. Each side sees two active-low status flags in its own clock domain. The write side sees full and almost-full. The read side sees empty and almost-empty.

Pointers are binary counters with one extra wrap bit. They cross to the other domain in Gray code through a two-stage synchronizer. This makes every flag conservative. A flag that depends on the far side's activity releases only on the second local clock edge after that activity. A flag that depends on local activity responds in the same cycle. One almost-threshold X serves both almost flags. X is picked from four presets by a select input that is sampled while reset is held.

Top module: `dcf_flagged_fifo`

## Requirements
- R1: While `rst_n` is low, and right after it rises with no traffic, the flags are in this state: `empty_n`=0, `almost_empty_n`=0, `full_n`=1, `almost_full_n`=1. `rd_data` is 0.
- R2: A read request while `empty_n` is low changes nothing. `rd_data` keeps its value, and the next word written later is the next word read.
- R3: A write request while `full_n` is low is dropped. The 64 words already stored come out unchanged and in order.
- R4: A read request with `empty_n` high loads the oldest stored word into `rd_data` on that read-clock edge. Words leave in the order they were written.
- R5: After a write, `empty_n` reflects the new fill level only from the second read-clock rising edge after the write edge. A read that takes the last word drives `empty_n` low on that same read edge.
- R6: `full_n` goes low on the write edge that stores the 64th word. After a read, it rises on the second write-clock rising edge following the read edge.
- R7: `almost_empty_n` is low when the read side counts X or fewer words and high when it counts X+1 or more. It uses the same read-side count and the same two-edge lag after writes as `empty_n`.
- R8: `almost_full_n` is low when the write side counts 64−X or more words and high otherwise. It follows writes in the same cycle and follows reads on the second write-clock edge.
- R9: `ofs_sel` is sampled on write-clock edges while `rst_n` is low. The encoding is 0→X=16, 1→X=12, 2→X=8, 3→X=4. Changes to `ofs_sel` after reset rises have no effect until the next reset.
- R10: Each pointer crosses domains in Gray code, so at most one bit of a crossing pointer changes per source-clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset for both sides |
| ofs_sel | input | 2 | Almost-threshold preset select, sampled during reset |
| wr_en | input | 1 | Write request |
| wr_data | input | 36 | Word to store |
| full_n | output | 1 | Low when no location is free (write domain) |
| almost_full_n | output | 1 | Low when 64−X or more words are stored (write domain) |
| rd_en | input | 1 | Read request |
| rd_data | output | 36 | Registered output word |
| empty_n | output | 1 | Low when no word is readable (read domain) |
| almost_empty_n | output | 1 | Low when X or fewer words are stored (read domain) |

## Verification
Some results are due in the same cycle as the stimulus:
- Write-side flags react to a write on the write edge that captures it.
- `rd_data`, `empty_n` and `almost_empty_n` react to a read on the read edge that takes it.

Other results cross domains and have a lag:
- Read-side flags take in a write only on the second read edge after it.
- Write-side flags take in a read only on the second write edge after it.

The two 200 MHz clocks are offset in phase, so for every push and pop the bench knows the edge order exactly. It samples the local flags on the falling edge right after the stimulus. It samples the far-side flags once after the first far-side edge, where the old level must still show, and once after the second edge, where the new level must show. This runs over every fill level from 0 to 64 for each of the four threshold presets.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

    localparam int unsigned GRAY_MAX_W = 16;

    typedef logic [GRAY_MAX_W-1:0] gray_word_t;

    typedef enum logic [1:0] {
        OFS_SEL_16 = 2'd0,
        OFS_SEL_12 = 2'd1,
        OFS_SEL_8  = 2'd2,
        OFS_SEL_4  = 2'd3
    } ofs_sel_e;

    function automatic gray_word_t to_gray(gray_word_t b);
        return b ^ (b >> 1);
    endfunction

    function automatic gray_word_t from_gray(gray_word_t g);
        gray_word_t b;
        b = g;
        for (int i = 1; i < GRAY_MAX_W; i++) begin
            b = b ^ (g >> i);
        end
        return b;
    endfunction

    // Threshold presets step down by four from sixteen.
    function automatic logic [7:0] ofs_value(logic [1:0] sel);
        return 8'd16 - {4'd0, sel, 2'b00};
    endfunction

endpackage

// File: rtl/dcf_sync2.sv
module dcf_sync2 #(
    parameter int unsigned W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.s1 = d;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q = st_q.s2;

endmodule

// File: rtl/dcf_ram.sv
module dcf_ram #(
    parameter int unsigned DATA_W = 36,
    parameter int unsigned ADDR_W = 6
) (
    input  logic              wr_clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge wr_clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/dcf_wr_side.sv
module dcf_wr_side
    import dcf_pkg::*;
#(
    parameter int unsigned ADDR_W = 6
) (
    input  logic              wr_clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W:0]   rd_gray_sync,
    input  logic [ADDR_W:0]   ofs,
    output logic [ADDR_W:0]   wr_gray,
    output logic [ADDR_W:0]   wr_ptr,
    output logic [ADDR_W-1:0] wr_addr,
    output logic              wr_fire,
    output logic              full_n,
    output logic              almost_full_n
);

    localparam int unsigned PTR_W = ADDR_W + 1;
    localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(1 << ADDR_W);

    typedef struct packed {
        logic [PTR_W-1:0] bin;
        logic [PTR_W-1:0] gray;
    } wstate_t;

    wstate_t st_d, st_q;
    logic [PTR_W-1:0] rd_bin;
    logic [PTR_W-1:0] level;
    logic             at_full;

    always_comb begin
        rd_bin  = PTR_W'(from_gray(gray_word_t'(rd_gray_sync)));
        level   = st_q.bin - rd_bin;
        at_full = (level == DEPTH_P);
        wr_fire = wr_en && !at_full;
        st_d.bin  = st_q.bin + PTR_W'(wr_fire);
        st_d.gray = PTR_W'(to_gray(gray_word_t'(st_d.bin)));
    end

    always_ff @(posedge wr_clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wr_gray       = st_q.gray;
    assign wr_ptr        = st_q.bin;
    assign wr_addr       = st_q.bin[ADDR_W-1:0];
    assign full_n        = !rst_n || !at_full;
    assign almost_full_n = !rst_n || (level < (DEPTH_P - ofs));

endmodule

// File: rtl/dcf_rd_side.sv
module dcf_rd_side
    import dcf_pkg::*;
#(
    parameter int unsigned DATA_W = 36,
    parameter int unsigned ADDR_W = 6
) (
    input  logic              rd_clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W:0]   wr_gray_sync,
    input  logic [ADDR_W:0]   ofs,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W:0]   rd_gray,
    output logic [ADDR_W:0]   rd_ptr,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              empty_n,
    output logic              almost_empty_n
);

    localparam int unsigned PTR_W = ADDR_W + 1;

    typedef struct packed {
        logic [PTR_W-1:0]  bin;
        logic [PTR_W-1:0]  gray;
        logic [DATA_W-1:0] dout;
    } rstate_t;

    rstate_t st_d, st_q;
    logic [PTR_W-1:0] wr_bin;
    logic [PTR_W-1:0] level;
    logic             rd_fire;

    always_comb begin
        wr_bin  = PTR_W'(from_gray(gray_word_t'(wr_gray_sync)));
        level   = wr_bin - st_q.bin;
        rd_fire = rd_en && (level != '0);
        st_d.bin  = st_q.bin + PTR_W'(rd_fire);
        st_d.gray = PTR_W'(to_gray(gray_word_t'(st_d.bin)));
        st_d.dout = rd_fire ? mem_rdata : st_q.dout;
    end

    always_ff @(posedge rd_clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_gray        = st_q.gray;
    assign rd_ptr         = st_q.bin;
    assign rd_addr        = st_q.bin[ADDR_W-1:0];
    assign rd_data        = st_q.dout;
    assign empty_n        = rst_n && (level != '0);
    assign almost_empty_n = rst_n && (level > ofs);

endmodule

// File: rtl/dcf_flagged_fifo.sv
module dcf_flagged_fifo
    import dcf_pkg::*;
#(
    parameter int unsigned DATA_W = 36,
    parameter int unsigned ADDR_W = 6
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              rst_n,
    input  logic [1:0]        ofs_sel,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              full_n,
    output logic              almost_full_n,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              empty_n,
    output logic              almost_empty_n
);

    localparam int unsigned PTR_W = ADDR_W + 1;

    logic [PTR_W-1:0]  wr_gray, rd_gray, wr_gray_rs, rd_gray_ws;
    logic [PTR_W-1:0]  wr_ptr_bin, rd_ptr_bin;
    logic [ADDR_W-1:0] wr_addr, rd_addr;
    logic [DATA_W-1:0] mem_rdata;
    logic              wr_fire;
    logic [PTR_W-1:0]  ofs_d, ofs_q;

    // Threshold register: loads only while reset is held, static afterwards.
    always_comb begin
        ofs_d = (!rst_n) ? PTR_W'(ofs_value(ofs_sel)) : ofs_q;
    end

    always_ff @(posedge wr_clk) begin
        ofs_q <= ofs_d;
    end

    dcf_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
        .wr_clk (wr_clk),
        .we     (wr_fire),
        .waddr  (wr_addr),
        .wdata  (wr_data),
        .raddr  (rd_addr),
        .rdata  (mem_rdata)
    );

    dcf_sync2 #(.W(PTR_W)) u_sync_w2r (
        .clk   (rd_clk),
        .rst_n (rst_n),
        .d     (wr_gray),
        .q     (wr_gray_rs)
    );

    dcf_sync2 #(.W(PTR_W)) u_sync_r2w (
        .clk   (wr_clk),
        .rst_n (rst_n),
        .d     (rd_gray),
        .q     (rd_gray_ws)
    );

    dcf_wr_side #(.ADDR_W(ADDR_W)) u_wr (
        .wr_clk        (wr_clk),
        .rst_n         (rst_n),
        .wr_en         (wr_en),
        .rd_gray_sync  (rd_gray_ws),
        .ofs           (ofs_q),
        .wr_gray       (wr_gray),
        .wr_ptr        (wr_ptr_bin),
        .wr_addr       (wr_addr),
        .wr_fire       (wr_fire),
        .full_n        (full_n),
        .almost_full_n (almost_full_n)
    );

    dcf_rd_side #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
        .rd_clk         (rd_clk),
        .rst_n          (rst_n),
        .rd_en          (rd_en),
        .wr_gray_sync   (wr_gray_rs),
        .ofs            (ofs_q),
        .mem_rdata      (mem_rdata),
        .rd_gray        (rd_gray),
        .rd_ptr         (rd_ptr_bin),
        .rd_addr        (rd_addr),
        .rd_data        (rd_data),
        .empty_n        (empty_n),
        .almost_empty_n (almost_empty_n)
    );

endmodule

// File: rtl/dcf_checker.sv
module dcf_checker #(
    parameter int unsigned DATA_W = 36,
    parameter int unsigned PTR_W  = 7
) (
    input logic              wr_clk,
    input logic              rd_clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic              full_n,
    input logic              almost_full_n,
    input logic              empty_n,
    input logic              almost_empty_n,
    input logic [DATA_W-1:0] rd_data,
    input logic [PTR_W-1:0]  wr_ptr,
    input logic [PTR_W-1:0]  rd_ptr,
    input logic [PTR_W-1:0]  wr_gray,
    input logic [PTR_W-1:0]  rd_gray,
    input logic [PTR_W-1:0]  ofs
);

    assert_no_overflow_R3: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (wr_en && !full_n) |=> $stable(wr_ptr));

    assert_no_underflow_R2: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (rd_en && !empty_n) |=> ($stable(rd_ptr) && $stable(rd_data)));

    assert_read_advance_R4: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (rd_en && empty_n) |=> ((rd_ptr - $past(rd_ptr)) == PTR_W'(1)));

    assert_full_implies_afull_R8: assert property (@(posedge wr_clk) disable iff (!rst_n)
        !full_n |-> !almost_full_n);

    assert_empty_implies_aempty_R7: assert property (@(posedge rd_clk) disable iff (!rst_n)
        !empty_n |-> !almost_empty_n);

    assert_wr_gray_step_R10: assert property (@(posedge wr_clk) disable iff (!rst_n)
        $countones(wr_gray ^ $past(wr_gray)) <= 1);

    assert_rd_gray_step_R10: assert property (@(posedge rd_clk) disable iff (!rst_n)
        $countones(rd_gray ^ $past(rd_gray)) <= 1);

    assert_ofs_held_R9: assert property (@(posedge wr_clk) disable iff (!rst_n)
        $stable(ofs));

endmodule

bind dcf_flagged_fifo dcf_checker #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_chk (
    .wr_clk         (wr_clk),
    .rd_clk         (rd_clk),
    .rst_n          (rst_n),
    .wr_en          (wr_en),
    .rd_en          (rd_en),
    .full_n         (full_n),
    .almost_full_n  (almost_full_n),
    .empty_n        (empty_n),
    .almost_empty_n (almost_empty_n),
    .rd_data        (rd_data),
    .wr_ptr         (wr_ptr_bin),
    .rd_ptr         (rd_ptr_bin),
    .wr_gray        (wr_gray),
    .rd_gray        (rd_gray),
    .ofs            (ofs_q)
);

// File: tb/tb_dcf_flagged_fifo.sv
`timescale 1ns/100ps
module tb_dcf_flagged_fifo;

    localparam int DW    = 36;
    localparam int DEPTH = 64;

    logic          wr_clk = 1'b0;
    logic          rd_clk = 1'b0;
    logic          rst_n  = 1'b0;
    logic [1:0]    ofs_sel = 2'd0;
    logic          wr_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          rd_en = 1'b0;
    logic          full_n, almost_full_n, empty_n, almost_empty_n;
    logic [DW-1:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    int xval   = 16;

    always #2.5 wr_clk = ~wr_clk;
    initial begin
        #1.5;
        forever begin
            rd_clk = ~rd_clk;
            #2.5;
        end
    end

    dcf_flagged_fifo dut (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .ofs_sel(ofs_sel),
        .wr_en(wr_en), .wr_data(wr_data), .full_n(full_n),
        .almost_full_n(almost_full_n), .rd_en(rd_en), .rd_data(rd_data),
        .empty_n(empty_n), .almost_empty_n(almost_empty_n)
    );

    function automatic logic [DW-1:0] pattern(int sel, int n);
        return {2'(sel), 2'b10, 8'(n), 24'hC3A500 ^ 24'(n * 7919)};
    endfunction

    task automatic chk(string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Write-side flags for a count of n words (R6, R8).
    task automatic wside(int n);
        chk("R6", "full_n", DW'(full_n), DW'(n < DEPTH));
        chk("R8", "almost_full_n", DW'(almost_full_n), DW'(n < DEPTH - xval));
    endtask

    // Read-side flags for a count of n words (R5, R7).
    task automatic rside(int n);
        chk("R5", "empty_n", DW'(empty_n), DW'(n > 0));
        chk("R7", "almost_empty_n", DW'(almost_empty_n), DW'(n > xval));
    endtask

    // Returns on the write-clock falling edge right after the capturing edge.
    task automatic push(logic [DW-1:0] d);
        @(negedge wr_clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge wr_clk);
        wr_en = 1'b0;
    endtask

    // Returns on the read-clock falling edge right after the capturing edge.
    task automatic pop();
        @(negedge rd_clk);
        rd_en = 1'b1;
        @(negedge rd_clk);
        rd_en = 1'b0;
    endtask

    task automatic do_reset(int sel);
        rst_n = 1'b0;
        ofs_sel = 2'(sel);
        wr_en = 1'b0;
        rd_en = 1'b0;
        repeat (4) @(negedge wr_clk);
        chk("R1", "full_n in reset", DW'(full_n), DW'(1));
        chk("R1", "empty_n in reset", DW'(empty_n), DW'(0));
        rst_n = 1'b1;
        @(negedge rd_clk);
        chk("R1", "empty_n", DW'(empty_n), DW'(0));
        chk("R1", "almost_empty_n", DW'(almost_empty_n), DW'(0));
        chk("R1", "full_n", DW'(full_n), DW'(1));
        chk("R1", "almost_full_n", DW'(almost_full_n), DW'(1));
        chk("R1", "rd_data", rd_data, '0);
        // R9: select changes after reset must not move the threshold
        ofs_sel = 2'(sel) ^ 2'b11;
    endtask

    initial begin
        for (int sel = 0; sel < 4; sel++) begin
            xval = 16 - 4 * sel;   // R9 encoding
            do_reset(sel);

            // Fill: local flags at once, far flags after two read edges (R5, R7, R10)
            for (int n = 1; n <= DEPTH; n++) begin
                push(pattern(sel, n - 1));
                wside(n);
                @(negedge rd_clk);
                rside(n - 1);
                @(negedge rd_clk);
                rside(n);
            end

            // R3: write while full is dropped
            push({DW{1'b1}});
            wside(DEPTH);
            @(negedge rd_clk);
            @(negedge rd_clk);
            rside(DEPTH);

            // Drain: data order (R4), write-side lag (R6, R8)
            for (int n = DEPTH; n >= 1; n--) begin
                pop();
                chk("R4", "rd_data", rd_data, pattern(sel, DEPTH - n));
                rside(n - 1);
                @(negedge wr_clk);
                wside(n);
                @(negedge wr_clk);
                wside(n - 1);
            end

            // R2: read while empty leaves data and pointer alone
            pop();
            chk("R2", "rd_data held", rd_data, pattern(sel, DEPTH - 1));
            chk("R2", "empty_n held", DW'(empty_n), DW'(0));
            push(pattern(sel, 200));
            @(negedge rd_clk);
            @(negedge rd_clk);
            pop();
            chk("R2", "next word after ignored read", rd_data, pattern(sel, 200));
            chk("R5", "empty_n after last word", DW'(empty_n), DW'(0));
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge wr_clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule